// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block takes one interrupt request, described by a routing entry (vector, delivery mode, destination mode, trigger mode and an 8-bit destination), and turns it into per-receiver delivery strobes for up to `N_RCV` local interrupt receivers. Each receiver supplies its physical ID, its logical ID, a bit choosing flat or cluster logical format, and a present bit. The block first builds a target mask from the destination. It then applies the delivery mode: the request goes to every target, or to one target picked by a rotating pointer, or nowhere.

A request is presented for one cycle on `req_i`. The strobes, the vector, the trigger bit and the unsupported flag are registered and appear for exactly one cycle, in the cycle that follows the request. The receivers' own priority handling is outside this block.

Top module: `irq_dest_resolver`

## Requirements
- R1: In physical destination mode (`req_logical_i`=0) the target is only the lowest-numbered present receiver whose physical ID equals `req_dest_i`; at most one strobe is set.
- R2: In logical destination mode (`req_logical_i`=1) a destination of zero selects no receiver.
- R3: A present receiver in flat format (`rcv_cluster_i` bit = 0) matches a logical destination when the bitwise AND of the destination and its logical ID is nonzero.
- R4: A present receiver in cluster format (bit = 1) matches when the upper nibble of its logical ID equals the upper nibble of the destination and the two lower nibbles share at least one set bit.
- R5: Delivery modes fixed (code 0) and external (code 7) strobe every receiver in the target mask, with `dlv_vec_o` and `dlv_trig_o` carrying the request's vector and trigger bit.
- R6: Lowest-priority mode (code 1) from a pin other than 0 strobes exactly one target: the first one at or after the rotation pointer, wrapping past `N_RCV`-1 to 0; the pointer then moves to the receiver after the chosen one, wrapping to 0.
- R7: Lowest-priority mode from pin 0 with a nonempty target mask strobes receiver 0 only (if present) and leaves the rotation pointer unchanged.
- R8: Delivery mode codes 2, 3, 4, 5 and 6 strobe no receiver and raise `unsup_o` for one cycle.
- R9: A receiver whose present bit is 0 is never strobed in any mode.
- R10: An empty target mask strobes nothing, raises no flag, and leaves the rotation pointer unchanged.
- R11: Results appear the cycle after the request and last one cycle; with no request all strobes and the flag are 0. Reset clears the outputs and sets the rotation pointer to receiver 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request valid, one cycle per request |
| req_pin_i | input | PIN_W | Input pin that raised the request |
| req_vec_i | input | VEC_W | Vector to deliver |
| req_dmode_i | input | 3 | Delivery mode code |
| req_logical_i | input | 1 | 0 = physical destination, 1 = logical destination |
| req_trig_i | input | 1 | Trigger mode forwarded to receivers |
| req_dest_i | input | ID_W | Destination field |
| rcv_present_i | input | N_RCV | Receiver present bits |
| rcv_phys_id_i | input | N_RCV*ID_W | Physical IDs, receiver i in slice i |
| rcv_log_id_i | input | N_RCV*ID_W | Logical IDs, receiver i in slice i |
| rcv_cluster_i | input | N_RCV | Logical format per receiver, 1 = cluster |
| dlv_strobe_o | output | N_RCV | One-cycle delivery strobe per receiver |
| dlv_vec_o | output | VEC_W | Vector of the delivery |
| dlv_trig_o | output | 1 | Trigger mode of the delivery |
| unsup_o | output | 1 | One-cycle flag for an unsupported delivery mode |

## Verification
Every result of this block is due in the single cycle after the request cycle: matching and selection are combinational and land in one output register stage, and the rotation pointer updates on that same edge, so it governs the next request. The bench drives each request on a falling edge, holds it through one rising edge, drops it on the next falling edge and samples the outputs there, half a cycle after they were registered. Rotation sequences are checked over back-to-back requests so that each pointer step is seen in the following strobe.

// File: rtl/irq_dest_pkg.sv
package irq_dest_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSV3   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSV6   = 3'd6,
    DM_EXTINT = 3'd7
  } dmode_e;
endpackage

// File: rtl/irq_dest_match.sv
// Builds the target mask from the destination field for all receivers.
module irq_dest_match #(
  parameter int N_RCV = 8,
  parameter int ID_W  = 8
) (
  input  logic                   logical_i,
  input  logic [ID_W-1:0]        dest_i,
  input  logic [N_RCV-1:0]       present_i,
  input  logic [N_RCV*ID_W-1:0]  phys_id_i,
  input  logic [N_RCV*ID_W-1:0]  log_id_i,
  input  logic [N_RCV-1:0]       cluster_i,
  output logic [N_RCV-1:0]       mask_o
);
  localparam int HALF = ID_W / 2;

  logic [N_RCV-1:0] phys_hit;
  logic [N_RCV-1:0] log_hit;
  logic [N_RCV-1:0] phys_first;

  for (genvar g = 0; g < N_RCV; g++) begin : g_rcv
    logic [ID_W-1:0] lid;
    logic            flat_hit;
    logic            clus_hit;
    assign lid         = log_id_i[g*ID_W +: ID_W];
    assign phys_hit[g] = present_i[g] && (phys_id_i[g*ID_W +: ID_W] == dest_i);
    assign flat_hit    = |(lid & dest_i);
    assign clus_hit    = (lid[ID_W-1:HALF] == dest_i[ID_W-1:HALF]) &&
                         (|(lid[HALF-1:0] & dest_i[HALF-1:0]));
    assign log_hit[g]  = present_i[g] && (|dest_i) &&
                         (cluster_i[g] ? clus_hit : flat_hit);
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    phys_first = '0;
    for (int i = 0; i < N_RCV; i++) begin
      if (!found && phys_hit[i]) begin
        phys_first[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign mask_o = logical_i ? log_hit : phys_first;
endmodule

// File: rtl/irq_dest_rr_pick.sv
// Picks the first candidate at or after the pointer, wrapping around.
module irq_dest_rr_pick #(
  parameter int N_RCV = 8,
  localparam int PW = (N_RCV > 1) ? $clog2(N_RCV) : 1
) (
  input  logic [N_RCV-1:0] cand_i,
  input  logic [PW-1:0]    ptr_i,
  output logic [N_RCV-1:0] pick_o,
  output logic [PW-1:0]    pick_idx_o
);
  always_comb begin
    logic found;
    int   j;
    found      = 1'b0;
    pick_o     = '0;
    pick_idx_o = '0;
    for (int k = 0; k < N_RCV; k++) begin
      j = int'(ptr_i) + k;
      if (j >= N_RCV) j = j - N_RCV;
      if (!found && cand_i[j]) begin
        found      = 1'b1;
        pick_o[j]  = 1'b1;
        pick_idx_o = PW'(j);
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_dest_pkg::*;
#(
  parameter int N_RCV = 8,
  parameter int ID_W  = 8,
  parameter int VEC_W = 8,
  parameter int PIN_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_i,
  input  logic [PIN_W-1:0]       req_pin_i,
  input  logic [VEC_W-1:0]       req_vec_i,
  input  logic [2:0]             req_dmode_i,
  input  logic                   req_logical_i,
  input  logic                   req_trig_i,
  input  logic [ID_W-1:0]        req_dest_i,
  input  logic [N_RCV-1:0]       rcv_present_i,
  input  logic [N_RCV*ID_W-1:0]  rcv_phys_id_i,
  input  logic [N_RCV*ID_W-1:0]  rcv_log_id_i,
  input  logic [N_RCV-1:0]       rcv_cluster_i,
  output logic [N_RCV-1:0]       dlv_strobe_o,
  output logic [VEC_W-1:0]       dlv_vec_o,
  output logic                   dlv_trig_o,
  output logic                   unsup_o
);
  localparam int PW = (N_RCV > 1) ? $clog2(N_RCV) : 1;
  localparam logic [PW-1:0] LAST = PW'(N_RCV - 1);

  logic [N_RCV-1:0] tgt;
  logic [N_RCV-1:0] pick;
  logic [PW-1:0]    pick_idx;
  logic [PW-1:0]    ptr_q;
  logic [N_RCV-1:0] nxt_strobe;
  logic             nxt_unsup;
  logic             adv_ptr;
  dmode_e           dmode;

  assign dmode = dmode_e'(req_dmode_i);

  irq_dest_match #(.N_RCV(N_RCV), .ID_W(ID_W)) match_i (
    .logical_i (req_logical_i),
    .dest_i    (req_dest_i),
    .present_i (rcv_present_i),
    .phys_id_i (rcv_phys_id_i),
    .log_id_i  (rcv_log_id_i),
    .cluster_i (rcv_cluster_i),
    .mask_o    (tgt)
  );

  irq_dest_rr_pick #(.N_RCV(N_RCV)) pick_i (
    .cand_i     (tgt),
    .ptr_i      (ptr_q),
    .pick_o     (pick),
    .pick_idx_o (pick_idx)
  );

  always_comb begin
    nxt_strobe = '0;
    nxt_unsup  = 1'b0;
    adv_ptr    = 1'b0;
    unique case (dmode)
      DM_FIXED, DM_EXTINT: nxt_strobe = tgt;
      DM_LOWEST: begin
        if (|tgt) begin
          if (req_pin_i == '0) begin
            nxt_strobe[0] = rcv_present_i[0];
          end else begin
            nxt_strobe = pick;
            adv_ptr    = 1'b1;
          end
        end
      end
      default: nxt_unsup = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_strobe_o <= '0;
      dlv_vec_o    <= '0;
      dlv_trig_o   <= 1'b0;
      unsup_o      <= 1'b0;
      ptr_q        <= '0;
    end else begin
      dlv_strobe_o <= req_i ? nxt_strobe : '0;
      unsup_o      <= req_i && nxt_unsup;
      if (req_i) begin
        dlv_vec_o  <= req_vec_i;
        dlv_trig_o <= req_trig_i;
      end
      if (req_i && adv_ptr) begin
        ptr_q <= (pick_idx == LAST) ? '0 : pick_idx + PW'(1);
      end
    end
  end
endmodule

// File: rtl/irq_dest_resolver_chk.sv
module irq_dest_resolver_chk #(
  parameter int N_RCV = 8,
  parameter int ID_W  = 8,
  parameter int VEC_W = 8,
  parameter int PIN_W = 5
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_i,
  input logic [PIN_W-1:0]       req_pin_i,
  input logic [2:0]             req_dmode_i,
  input logic                   req_logical_i,
  input logic [ID_W-1:0]        req_dest_i,
  input logic [N_RCV-1:0]       rcv_present_i,
  input logic [N_RCV-1:0]       dlv_strobe_o,
  input logic                   unsup_o
);
  p_phys_single_r1: assert property (@(posedge clk) disable iff (rst)
    (req_i && !req_logical_i) |=> $onehot0(dlv_strobe_o));

  p_zero_dest_r2: assert property (@(posedge clk) disable iff (rst)
    (req_i && req_logical_i && req_dest_i == '0) |=> (dlv_strobe_o == '0));

  p_lowest_one_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && req_dmode_i == 3'd1) |=> $onehot0(dlv_strobe_o));

  p_pin0_recv0_r7: assert property (@(posedge clk) disable iff (rst)
    (req_i && req_dmode_i == 3'd1 && req_pin_i == '0) |=>
      ((dlv_strobe_o >> 1) == '0));

  p_unsup_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    unsup_o |-> (dlv_strobe_o == '0));

  p_present_only_r9: assert property (@(posedge clk) disable iff (rst)
    req_i |=> ((dlv_strobe_o & ~$past(rcv_present_i)) == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (dlv_strobe_o == '0 && !unsup_o));
endmodule

bind irq_dest_resolver irq_dest_resolver_chk #(
  .N_RCV(N_RCV), .ID_W(ID_W), .VEC_W(VEC_W), .PIN_W(PIN_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .req_pin_i     (req_pin_i),
  .req_dmode_i   (req_dmode_i),
  .req_logical_i (req_logical_i),
  .req_dest_i    (req_dest_i),
  .rcv_present_i (rcv_present_i),
  .dlv_strobe_o  (dlv_strobe_o),
  .unsup_o       (unsup_o)
);

// File: tb/irq_dest_resolver_tb_top.sv
module irq_dest_resolver_tb_top;
  localparam int N = 4;
  localparam int ID_W = 8;
  localparam int VEC_W = 8;
  localparam int PIN_W = 5;
  localparam int NVEC = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [PIN_W-1:0] pin = '0;
  logic [VEC_W-1:0] vec = '0;
  logic [2:0] dmode = '0;
  logic logical = 1'b0;
  logic trig = 1'b0;
  logic [ID_W-1:0] dest = '0;
  logic [N-1:0] present = 4'b1111;
  logic [N*ID_W-1:0] phys_id = {8'h13, 8'h11, 8'h11, 8'h10};
  logic [N*ID_W-1:0] log_id  = {8'h22, 8'h21, 8'h02, 8'h01};
  logic [N-1:0] cluster = 4'b1100;
  logic [N-1:0] strobe;
  logic [VEC_W-1:0] o_vec;
  logic o_trig;
  logic o_unsup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_dest_resolver #(.N_RCV(N), .ID_W(ID_W), .VEC_W(VEC_W), .PIN_W(PIN_W)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .req_pin_i(pin), .req_vec_i(vec),
    .req_dmode_i(dmode), .req_logical_i(logical), .req_trig_i(trig),
    .req_dest_i(dest), .rcv_present_i(present), .rcv_phys_id_i(phys_id),
    .rcv_log_id_i(log_id), .rcv_cluster_i(cluster), .dlv_strobe_o(strobe),
    .dlv_vec_o(o_vec), .dlv_trig_o(o_trig), .unsup_o(o_unsup)
  );

  // {pin, mode, logical, dest, vector, trig, expected strobes, expected flag}
  localparam logic [30:0] TBL [NVEC] = '{
    {5'd1,  3'd0, 1'b0, 8'h11, 8'h41, 1'b0, 4'b0010, 1'b0}, // R1 first of two equal IDs
    {5'd2,  3'd0, 1'b0, 8'h13, 8'h42, 1'b1, 4'b1000, 1'b0}, // R1
    {5'd3,  3'd0, 1'b0, 8'h55, 8'h43, 1'b0, 4'b0000, 1'b0}, // R10
    {5'd4,  3'd0, 1'b1, 8'h00, 8'h44, 1'b0, 4'b0000, 1'b0}, // R2
    {5'd5,  3'd0, 1'b1, 8'h03, 8'h45, 1'b1, 4'b0011, 1'b0}, // R3
    {5'd6,  3'd0, 1'b1, 8'h23, 8'h46, 1'b0, 4'b1111, 1'b0}, // R4
    {5'd7,  3'd0, 1'b1, 8'h24, 8'h47, 1'b0, 4'b0000, 1'b0}, // R4 no shared low bit
    {5'd8,  3'd7, 1'b1, 8'h22, 8'h48, 1'b1, 4'b1010, 1'b0}, // R5 external mode
    {5'd9,  3'd4, 1'b0, 8'h10, 8'h49, 1'b0, 4'b0000, 1'b1}, // R8
    {5'd10, 3'd2, 1'b0, 8'h10, 8'h4a, 1'b0, 4'b0000, 1'b1}, // R8
    {5'd11, 3'd5, 1'b1, 8'h23, 8'h4b, 1'b0, 4'b0000, 1'b1}, // R8
    {5'd12, 3'd3, 1'b0, 8'h10, 8'h4c, 1'b0, 4'b0000, 1'b1}, // R8
    {5'd13, 3'd6, 1'b0, 8'h10, 8'h4d, 1'b0, 4'b0000, 1'b1}  // R8
  };
  string tags [NVEC] = '{"R1", "R1", "R10", "R2", "R3", "R4", "R4", "R5",
                         "R8", "R8", "R8", "R8", "R8"};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // Drive a request for one cycle; outputs are sampled on the falling edge after it.
  task automatic send(input logic [4:0] p, input logic [2:0] m, input logic l,
                      input logic [7:0] d, input logic [7:0] v, input logic t);
    @(negedge clk);
    req = 1'b1; pin = p; dmode = m; logical = l; dest = d; vec = v; trig = t;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic lowest(input string tag, input logic [4:0] p, input logic [7:0] d,
                        input logic [3:0] exp);
    send(p, 3'd1, 1'b1, d, 8'h60, 1'b0);
    check(tag, 32'(strobe), 32'(exp));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", 32'({strobe, o_unsup, o_trig}), 32'h0);
    check("R11", 32'(o_vec), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [30:0] e;
      e = TBL[i];
      send(e[30:26], e[25:23], e[22], e[21:14], e[13:6], e[5]);
      check(tags[i], 32'(strobe), 32'(e[4:1]));
      check(tags[i], 32'(o_unsup), 32'(e[0]));
      if (e[4:1] != 4'b0000) begin
        check("R5", 32'(o_vec), 32'(e[13:6]));
        check("R5", 32'(o_trig), 32'(e[5]));
      end
    end

    // R11: strobes last one cycle
    @(negedge clk);
    check("R11", 32'({strobe, o_unsup}), 32'h0);

    // R6 rotation over the full mask, with wrap
    lowest("R6", 5'd5, 8'h23, 4'b0001);
    lowest("R6", 5'd5, 8'h23, 4'b0010);
    lowest("R6", 5'd5, 8'h23, 4'b0100);
    lowest("R6", 5'd5, 8'h23, 4'b1000);
    lowest("R6", 5'd5, 8'h23, 4'b0001);
    // R7 pin 0 goes to receiver 0, pointer stays at 1
    lowest("R7", 5'd0, 8'h23, 4'b0001);
    lowest("R7", 5'd5, 8'h23, 4'b0010);
    // R6 sparse mask {1,3} from pointer 2
    lowest("R6", 5'd5, 8'h22, 4'b1000);
    lowest("R6", 5'd5, 8'h22, 4'b0010);
    // R10 empty mask keeps pointer at 2
    lowest("R10", 5'd5, 8'h24, 4'b0000);
    check("R10", 32'(o_unsup), 32'h0);
    lowest("R10", 5'd5, 8'h23, 4'b0100);
    // R9 receiver 3 removed: pointer 3 wraps to receiver 0
    present = 4'b0111;
    lowest("R9", 5'd5, 8'h23, 4'b0001);
    send(5'd2, 3'd0, 1'b0, 8'h13, 8'h70, 1'b0);
    check("R9", 32'(strobe), 32'h0);
    send(5'd2, 3'd0, 1'b1, 8'h23, 8'h71, 1'b0);
    check("R9", 32'(strobe), 32'h7);
    present = 4'b1111;
    // R11 reset returns pointer to receiver 0 (it was at 1)
    lowest("R6", 5'd5, 8'h23, 4'b0010);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    lowest("R11", 5'd5, 8'h23, 4'b0001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule